// File: doc/BRIEF.md
# Paged Address Translator with Two-Level Table Walk

This block turns 32-bit virtual addresses into 32-bit physical addresses for 4 KB pages. Each request is first compared against a small, fully associative cache of recent page mappings. When that comparison finds the page, the physical address comes back on the next cycle. When it does not, a hardware walker fetches the needed entries from memory. It first reads an entry from a first-level directory, and then, only if that directory slot is populated, it reads an entry from a second-level table. A successful walk writes the mapping into the cache and returns the translated address. An empty entry at either level returns a fault.

The client offers an address with a valid/ready handshake and gets back a single-cycle response pulse carrying either the physical address or a fault flag. The walker reads memory through a simple port: a one-cycle request pulse with an address, answered later by a one-cycle response pulse with a 32-bit word. The base of the directory is a plain input. A flush input drops every cached mapping.

Top module: `vxl_mmu`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the cache holds no mappings, so the first translation of any page walks memory.
- R2: The virtual page number is `req_vaddr[31:12]`. A translated address is `{ppn, req_vaddr[11:0]}`, so the low 12 bits pass through unchanged.
- R3: A request that finds its page in the cache gets `rsp_valid`=1 with `rsp_fault`=0 exactly one cycle after it is accepted. It causes no memory read, and `req_ready` stays 1.
- R4: On a miss, the first read is at `dir_base + 4*req_vaddr[31:22]`. If bit 0 of that word is 1, the second read is at `{word[31:12], req_vaddr[21:12], 2'b00}`. If bit 0 of the second word is 1, the physical page number is `word2[31:12]`.
- R5: A directory word with bit 0 equal to 0 ends the walk after that one read, with `rsp_fault`=1 and `rsp_paddr`=0.
- R6: A table word with bit 0 equal to 0 ends the walk after two reads, with `rsp_fault`=1 and `rsp_paddr`=0. The failed mapping is not cached, so repeating the request walks again.
- R7: Only one walk is in progress at a time. `req_ready` is 0 from the cycle after a missing request is accepted until its response, and each memory request is a single-cycle pulse.
- R8: A successful walk installs the mapping, so a later request to the same page hits.
- R9: The cache holds 32 mappings and replaces them in round-robin order. Starting from empty, after 40 distinct successful walks the first 8 pages miss and the last 32 hit.
- R10: A one-cycle pulse on `flush` removes all mappings in that cycle, so the next request to any page walks memory.
- R11: A request accepted in the same cycle as `flush` is handled as a miss, even when its page was cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drops all cached mappings |
| dir_base | input | 32 | Byte address of the first-level directory |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Read data word |

## Verification
A cached page must answer exactly one cycle after acceptance. The bench samples the response on the falling edge right after the accepting rising edge and requires a latency of one. A walk takes a number of cycles set by the memory model's latency, so for misses the bench polls on every falling edge until the response appears. It checks that `req_ready` stayed low while waiting, and it counts the memory reads issued between acceptance and response. Those read counts (0, 1 or 2) separate hits, empty directory slots, and full walks. All page-table contents, physical addresses and fault outcomes are computed in the bench from index arithmetic.

// File: rtl/vxl_pkg.sv
package vxl_pkg;

    parameter int ADDR_W = 32;
    parameter int OFF_W  = 12;
    parameter int VPN_W  = ADDR_W - OFF_W;
    parameter int IDX_W  = VPN_W / 2;
    parameter int ENT_SH = OFF_W - IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_REQ,
        W_DIR_WAIT,
        W_TBL_REQ,
        W_TBL_WAIT,
        W_FILL,
        W_RESP
    } walk_st_e;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        vpn_t ppn;
    } tlb_ent_t;

    function automatic idx_t dir_index(input addr_t va);
        return va[ADDR_W-1 -: IDX_W];
    endfunction

    function automatic idx_t tbl_index(input addr_t va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic vpn_t page_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

endpackage

// File: rtl/vxl_tlb.sv
module vxl_tlb
    import vxl_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  vpn_t look_vpn,
    output logic hit,
    output vpn_t hit_ppn,
    input  logic fill_en,
    input  vpn_t fill_vpn,
    input  vpn_t fill_ppn
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    tlb_ent_t           ent [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] valid_vec;
    logic [PTR_W-1:0]   ptr;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign valid_vec[g] = ent[g].valid;
            assign match[g]     = ent[g].valid && (ent[g].vpn == look_vpn);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        hit_ppn = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (match[k]) hit_ppn = hit_ppn | ent[k].ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int k = 0; k < ENTRIES; k++) ent[k].valid <= 1'b0;
            ptr <= '0;
        end else if (fill_en) begin
            ent[ptr] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn};
            ptr      <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R8: at most one cached mapping may match a page
    a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R10: a flush leaves no valid mapping behind
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/vxl_walker.sv
module vxl_walker
    import vxl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t start_va,
    input  addr_t dir_base,
    output logic  idle,
    output logic  mem_req_valid,
    output addr_t mem_req_addr,
    input  logic  mem_rsp_valid,
    input  addr_t mem_rsp_data,
    output logic  done,
    output logic  done_fault,
    output addr_t done_paddr,
    output logic  fill_en,
    output vpn_t  fill_vpn,
    output vpn_t  fill_ppn
);

    walk_st_e st;
    addr_t    va_q;
    vpn_t     frame_q;
    logic     fault_q;
    logic     present;
    logic     unused_flag_bits;

    assign present          = mem_rsp_data[0];
    assign unused_flag_bits = ^mem_rsp_data[OFF_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= W_IDLE;
            va_q    <= '0;
            frame_q <= '0;
            fault_q <= 1'b0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (start) begin
                        va_q    <= start_va;
                        fault_q <= 1'b0;
                        st      <= W_DIR_REQ;
                    end
                end
                W_DIR_REQ: st <= W_DIR_WAIT;
                W_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (present) begin
                            frame_q <= page_of(mem_rsp_data);
                            st      <= W_TBL_REQ;
                        end else begin
                            fault_q <= 1'b1;
                            st      <= W_RESP;
                        end
                    end
                end
                W_TBL_REQ: st <= W_TBL_WAIT;
                W_TBL_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (present) begin
                            frame_q <= page_of(mem_rsp_data);
                            st      <= W_FILL;
                        end else begin
                            fault_q <= 1'b1;
                            st      <= W_RESP;
                        end
                    end
                end
                W_FILL:  st <= W_RESP;
                W_RESP:  st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    assign idle          = (st == W_IDLE);
    assign mem_req_valid = (st == W_DIR_REQ) || (st == W_TBL_REQ);
    assign mem_req_addr  = (st == W_TBL_REQ)
                         ? addr_t'({frame_q, tbl_index(va_q), {ENT_SH{1'b0}}})
                         : dir_base + addr_t'({dir_index(va_q), {ENT_SH{1'b0}}});

    assign done       = (st == W_RESP);
    assign done_fault = fault_q;
    assign done_paddr = fault_q ? '0 : {frame_q, va_q[OFF_W-1:0]};
    assign fill_en    = (st == W_FILL);
    assign fill_vpn   = page_of(va_q);
    assign fill_ppn   = frame_q;

    // R7: every memory request lasts a single cycle
    a_r7_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R5: an empty directory word ends the walk with a fault and no table read
    a_r5_dir_fault: assert property (@(posedge clk) disable iff (rst)
        (st == W_DIR_WAIT && mem_rsp_valid && !present)
            |=> (done && done_fault && !mem_req_valid));

    // R6: an empty table word never installs a mapping
    a_r6_no_fault_fill: assert property (@(posedge clk) disable iff (rst)
        (st == W_TBL_WAIT && mem_rsp_valid && !present) |=> !fill_en);

endmodule

// File: rtl/vxl_mmu.sv
module vxl_mmu
    import vxl_pkg::*;
#(
    parameter int TLB_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);

    logic  tlb_hit;
    vpn_t  tlb_ppn;
    logic  use_hit;
    logic  accept;
    logic  walk_start;
    logic  walk_idle;
    logic  walk_done;
    logic  walk_fault;
    addr_t walk_paddr;
    logic  fill_en;
    vpn_t  fill_vpn;
    vpn_t  fill_ppn;
    logic  hit_q;
    addr_t hit_pa_q;

    vxl_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .look_vpn (page_of(req_vaddr)),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn)
    );

    vxl_walker u_walk (
        .clk           (clk),
        .rst           (rst),
        .start         (walk_start),
        .start_va      (req_vaddr),
        .dir_base      (dir_base),
        .idle          (walk_idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (walk_done),
        .done_fault    (walk_fault),
        .done_paddr    (walk_paddr),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_ppn      (fill_ppn)
    );

    assign req_ready  = walk_idle;
    assign accept     = req_valid && req_ready;
    assign use_hit    = tlb_hit && !flush;
    assign walk_start = accept && !use_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q    <= 1'b0;
            hit_pa_q <= '0;
        end else begin
            hit_q    <= accept && use_hit;
            hit_pa_q <= {tlb_ppn, req_vaddr[OFF_W-1:0]};
        end
    end

    assign rsp_valid = hit_q || walk_done;
    assign rsp_fault = walk_done && walk_fault;
    assign rsp_paddr = hit_q ? hit_pa_q : walk_paddr;

    // R3: a cached page answers on the next cycle without a fault
    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && tlb_hit && !flush) |=> (rsp_valid && !rsp_fault && req_ready));

    // R7: a miss closes the request port while its walk runs
    a_r7_busy_on_miss: assert property (@(posedge clk) disable iff (rst)
        walk_start |=> !req_ready);

    // R11: a request in a flush cycle is sent to the walker
    a_r11_flush_is_miss: assert property (@(posedge clk) disable iff (rst)
        (accept && flush) |=> (!rsp_valid && !req_ready));

endmodule

// File: tb/vxl_mmu_test.sv
`timescale 1ns/1ps
module vxl_mmu_test;

    localparam logic [31:0] DIR_BASE = 32'h0010_0000;
    localparam int          MEM_LAT  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int bad    = 0;
    int rd_total = 0;

    always #2.5 clk = ~clk;

    vxl_mmu uut (
        .clk(clk), .rst(rst), .flush(flush), .dir_base(DIR_BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic dir_empty(input int i);
        return (i % 3) == 2;
    endfunction

    function automatic logic pte_empty(input int j);
        return (j % 5) == 4;
    endfunction

    function automatic logic [19:0] exp_ppn(input int i, input int j);
        return 20'(i * 37 + j * 11 + 5);
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int i, j;
        if (a >= DIR_BASE && a < DIR_BASE + 32'd4096) begin
            i = int'((a - DIR_BASE) >> 2);
            if (dir_empty(i)) return 32'h0;
            return {20'(32'h200 + 32'(i)), 12'h001};
        end
        i = int'(a >> 12) - 32'h200;
        j = int'((a >> 2) & 32'h3FF);
        if (pte_empty(j)) return 32'h0;
        return {exp_ppn(i, j), 12'h001};
    endfunction

    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          delay = 0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            delay     <= MEM_LAT;
            rd_total  <= rd_total + 1;
        end else if (pend) begin
            if (delay <= 1) begin
                pend          <= 1'b0;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_word(pend_addr);
            end else begin
                delay <= delay - 1;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] va, input logic fl,
                         output logic [31:0] pa, output logic flt,
                         output int reads, output int lat, output logic rdy_bad);
        int r0;
        int guard;
        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1;
        req_vaddr = va;
        flush     = fl;
        r0        = rd_total;
        @(negedge clk);
        req_valid = 1'b0;
        flush     = 1'b0;
        lat       = 1;
        rdy_bad   = 1'b0;
        while (!rsp_valid && lat < 300) begin
            if (req_ready) rdy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (!rsp_valid) check("watchdog", "response", 32'd0, 32'd1);
        pa    = rsp_paddr;
        flt   = rsp_fault;
        reads = rd_total - r0;
    endtask

    task automatic run(input string tag, input int i, input int j, input int off,
                       input logic fl, input logic want_hit);
        logic [31:0] va, pa, epa;
        logic        flt, efl, rb;
        int          reads, lat, er;
        va  = {i[9:0], j[9:0], off[11:0]};
        efl = dir_empty(i) || pte_empty(j);
        epa = efl ? 32'h0 : {exp_ppn(i, j), off[11:0]};
        er  = want_hit ? 0 : (dir_empty(i) ? 1 : 2);
        xlate(va, fl, pa, flt, reads, lat, rb);
        check(tag, "fault", {31'b0, flt}, {31'b0, efl});
        check(tag, "paddr", pa, epa);
        check(tag, "reads", 32'(reads), 32'(er));
        if (want_hit) check(tag, "latency", 32'(lat), 32'd1);
        else          check({tag, " R7"}, "ready-low-while-walking", {31'b0, rb}, 32'd0);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic int sweep_j(input int k);
        return (k / 4) * 5 + (k % 4);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog", "run-finished", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs after reset
        check("R1", "req_ready", {31'b0, req_ready}, 32'd1);
        check("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);

        // R1 R4: first access walks; R2 offset passes through
        run("R1 R4 R2", 0, 7, 'h019, 1'b0, 1'b0);
        // R3 R8: same page now hits
        run("R3 R8 R2", 0, 7, 'hFFF, 1'b0, 1'b1);
        run("R4 R2", 1, 9 + 1, 'hABC, 1'b0, 1'b0);
        run("R3 R2", 1, 10, 'h000, 1'b0, 1'b1);

        // R5: empty directory slots
        run("R5", 2, 3, 'h123, 1'b0, 1'b0);
        run("R5", 5, 100, 'h456, 1'b0, 1'b0);
        run("R5", 1022, 0, 'h001, 1'b0, 1'b0);
        // R6: empty table entries, not cached
        run("R6", 0, 4, 'h010, 1'b0, 1'b0);
        run("R6", 0, 4, 'h020, 1'b0, 1'b0);

        // R4 R5 R6: sweep of directory and table patterns, then revisit
        for (int i = 0; i < 12; i++) begin
            run("R4 sweep", i, 0, i * 3, 1'b0, 1'b0);
            run("R4 sweep", i, 1, i * 5, 1'b0, 1'b0);
            run("R6 sweep", i, 9, i, 1'b0, 1'b0);
            run("R4 sweep", i, 1023, 'hFFF - i, 1'b0, 1'b0);
        end
        for (int i = 0; i < 12; i++) begin
            run("R8 revisit", i, 0, 7, 1'b0, !dir_empty(i));
            run("R8 revisit", i, 1023, 9, 1'b0, !dir_empty(i));
            run("R6 revisit", i, 9, 1, 1'b0, 1'b0);
        end

        // R9: round-robin replacement over 32 slots
        pulse_flush();
        for (int k = 0; k < 40; k++)
            run("R9 fill", 3 + (k % 2), sweep_j(k), k, 1'b0, 1'b0);
        for (int k = 8; k < 40; k++)
            run("R9 kept", 3 + (k % 2), sweep_j(k), 'h800 + k, 1'b0, 1'b1);
        run("R9 evicted", 3, sweep_j(0), 'h0AA, 1'b0, 1'b0);

        // R10: flush empties the cache
        run("R10 before", 4, sweep_j(39), 'h005, 1'b0, 1'b1);
        pulse_flush();
        run("R10 after", 4, sweep_j(39), 'h006, 1'b0, 1'b0);
        run("R10 refill", 4, sweep_j(39), 'h007, 1'b0, 1'b1);

        // R11: request in the flush cycle misses
        run("R11", 4, sweep_j(39), 'h008, 1'b1, 1'b0);
        run("R11 after", 4, sweep_j(39), 'h009, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule